// File: doc/BRIEF.md
# TDM Bearer-Channel Longword Buffer

This block sits between a serial time-division voice line and a 32-bit processor register interface, for one bearer channel in both directions. Each frame carries an 8-bit slot. The frame starts with a frame-sync pulse and is timed by a bit strobe. On receive, the block assembles four consecutive slots into one 32-bit word. The first slot lands in the most significant byte. After the eighth bit of the fourth slot, the block copies the word into a readable receive register. In the same cycle it raises a single-cycle interrupt that serves both directions. With 8 kHz frames, these transfers happen at 2 kHz.

On transmit, the processor writes a 32-bit word into a holding register. At each four-frame boundary, the holding word moves into a transmit shadow. The shadow is then sent one byte per frame over the next four frames, most significant byte first. If the processor writes nothing new, the same word is sent again. A mode input picks the bit order within each byte. It is either most significant bit first (plain voice samples) or least significant bit first (bit-stuffed link data), and it applies to both directions. A sticky flag records each interrupt until the processor clears it.

The block runs on one system clock. `bit_tick` is a one-cycle enable for each line bit, and `fsync` marks the first bit of a slot when it is high together with `bit_tick`.

Top module: `tdm_bchan_buffer`

## Requirements
- R1: After reset, `rx_word` is 32'hFFFFFFFF, `irq` and `irq_flag` are 0, `ser_out` is 1, and the transmit shadow holds all ones, so the first four slots after reset send only ones.
- R2: A slot opens on a `bit_tick` with `fsync` high and takes eight ticks. Slot k (k = 0..3, counted from reset) fills `rx_word[31-8k -: 8]`. `rx_word` takes the new word one clock after the tick that carries the eighth bit of slot 3.
- R3: With `lsb_first`=0, the first line bit of a slot is byte bit 7 and the last is bit 0, on both `ser_in` and `ser_out`.
- R4: With `lsb_first`=1, the first line bit of a slot is byte bit 0 and the last is bit 7, on both `ser_in` and `ser_out`.
- R5: `irq` is high for exactly one clock, in the same cycle that `rx_word` updates. It is never high at any other time.
- R6: `irq_flag` goes to 1 with each `irq` and stays at 1 until `flag_clr` is high at a clock edge without a concurrent `irq`. An `irq` wins over a simultaneous `flag_clr`.
- R7: At each four-slot boundary, the holding word (written by `tx_wr` with `tx_data`) moves into the transmit shadow. Over the next four slots, slot k sends shadow bits [31-8k -: 8]. Each bit appears on `ser_out` one clock after its tick and holds until the next tick.
- R8: If no `tx_wr` happens between two boundaries, the previous transmit word is sent again. A `tx_wr` during a four-slot group does not change the bytes of that group.
- R9: A `bit_tick` without `fsync` after a slot's eighth bit is ignored. It changes neither the assembled receive data nor the slot count, and it drives `ser_out` to 1 one clock later.
- R10: `rx_word` holds its value between boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per line bit |
| fsync | input | 1 | With bit_tick: first bit of a slot |
| ser_in | input | 1 | Serial receive data, sampled on bit_tick |
| lsb_first | input | 1 | Bit order: 0 msb first, 1 lsb first |
| tx_wr | input | 1 | Write strobe for the transmit holding word |
| tx_data | input | 32 | Transmit word written by tx_wr |
| flag_clr | input | 1 | Clears the sticky interrupt flag |
| ser_out | output | 1 | Serial transmit data |
| rx_word | output | 32 | Last complete four-slot receive word |
| irq | output | 1 | One-cycle transfer interrupt |
| irq_flag | output | 1 | Sticky copy of irq |

## Verification
Each serial output bit is due one clock after the tick that carries it. The bench drives every tick for one cycle starting at a falling edge and reads `ser_out` at the next falling edge. `rx_word`, `irq` and `irq_flag` are also due one clock after the eighth tick of slot 3, so they are read at that same falling edge. One clock later the bench confirms that `irq` has dropped. At the end of each earlier slot it confirms that `rx_word` still holds the previous word. Words, modes, holding-register writes, idle ticks between slots and flag clears are drawn from a seeded `$urandom`, and directed cases cover reset, repetition and mid-group writes.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef enum logic {
    ORDER_MSB_FIRST = 1'b0,
    ORDER_LSB_FIRST = 1'b1
  } bit_order_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 4,
  parameter int BIT_W     = $clog2(SLOT_BITS),
  parameter int FRM_W     = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             fsync,
  output logic             bit_valid,
  output logic [BIT_W-1:0] slot_idx,
  output logic [FRM_W-1:0] frame_cnt,
  output logic             last_bit,
  output logic             word_end
);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(SLOT_BITS - 1);
  localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(SLOTS - 1);

  logic             active_q, active_d;
  logic [BIT_W-1:0] bit_cnt_q, bit_cnt_d;
  logic [FRM_W-1:0] frame_cnt_d;

  assign slot_idx  = fsync ? '0 : bit_cnt_q;
  assign bit_valid = bit_tick && (fsync || active_q);
  assign last_bit  = bit_valid && (slot_idx == LAST_IDX);
  assign word_end  = last_bit && (frame_cnt == LAST_FRM);

  always_comb begin
    active_d    = active_q;
    bit_cnt_d   = bit_cnt_q;
    frame_cnt_d = frame_cnt;
    if (bit_valid) begin
      if (last_bit) begin
        active_d    = 1'b0;
        bit_cnt_d   = '0;
        frame_cnt_d = (frame_cnt == LAST_FRM) ? '0 : frame_cnt + 1'b1;
      end else begin
        active_d  = 1'b1;
        bit_cnt_d = slot_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      bit_cnt_q <= '0;
      frame_cnt <= '0;
    end else if (bit_valid) begin
      active_q  <= active_d;
      bit_cnt_q <= bit_cnt_d;
      frame_cnt <= frame_cnt_d;
    end
  end

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && frame_cnt != LAST_FRM) |=> (frame_cnt == $past(frame_cnt) + 1'b1)); // R2
  AST_IDLE_TICK_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !bit_valid) |=> $stable(frame_cnt)); // R9
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 4,
  parameter int BIT_W     = $clog2(SLOT_BITS),
  parameter int FRM_W     = $clog2(SLOTS),
  parameter int WORD_W    = SLOT_BITS * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  bit_order_e        order,
  input  logic              bit_valid,
  input  logic [FRM_W-1:0]  frame_cnt,
  input  logic              last_bit,
  input  logic              word_end,
  output logic [WORD_W-1:0] rx_word
);
  logic [SLOT_BITS-1:0] shift_q, shift_d;
  logic [WORD_W-1:0]    pack_q, pack_d;

  always_comb begin
    if (order == ORDER_LSB_FIRST) shift_d = {ser_in, shift_q[SLOT_BITS-1:1]};
    else                          shift_d = {shift_q[SLOT_BITS-2:0], ser_in};
  end

  for (genvar l = 0; l < SLOTS; l++) begin : g_lane
    assign pack_d[WORD_W-1-l*SLOT_BITS -: SLOT_BITS] =
      (last_bit && frame_cnt == FRM_W'(l)) ? shift_d
                                           : pack_q[WORD_W-1-l*SLOT_BITS -: SLOT_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      pack_q  <= '1;
      rx_word <= '1;
    end else begin
      if (bit_valid) shift_q <= shift_d;
      if (last_bit)  pack_q  <= pack_d;
      if (word_end)  rx_word <= pack_d;
    end
  end

  AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_end |=> $stable(rx_word)); // R10
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 4,
  parameter int BIT_W     = $clog2(SLOT_BITS),
  parameter int FRM_W     = $clog2(SLOTS),
  parameter int WORD_W    = SLOT_BITS * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_data,
  input  bit_order_e        order,
  input  logic              bit_tick,
  input  logic              bit_valid,
  input  logic [BIT_W-1:0]  slot_idx,
  input  logic [FRM_W-1:0]  frame_cnt,
  input  logic              word_end,
  output logic              ser_out
);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(SLOT_BITS - 1);

  logic [WORD_W-1:0]    hold_q;
  logic [WORD_W-1:0]    shadow_q;
  logic [SLOT_BITS-1:0] lane_byte;
  logic [BIT_W-1:0]     pick;
  logic                 ser_d;

  always_comb begin
    lane_byte = '1;
    for (int l = 0; l < SLOTS; l++) begin
      if (frame_cnt == FRM_W'(l))
        lane_byte = shadow_q[WORD_W-1-l*SLOT_BITS -: SLOT_BITS];
    end
    pick  = (order == ORDER_LSB_FIRST) ? slot_idx : LAST_IDX - slot_idx;
    ser_d = bit_valid ? lane_byte[pick] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '1;
      shadow_q <= '1;
      ser_out  <= 1'b1;
    end else begin
      if (tx_wr)    hold_q   <= tx_data;
      if (word_end) shadow_q <= hold_q;
      if (bit_tick) ser_out  <= ser_d;
    end
  end

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_end |=> $stable(shadow_q)); // R8
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !bit_valid) |=> ser_out); // R9
endmodule

// File: rtl/tdm_bchan_buffer.sv
module tdm_bchan_buffer
  import tdm_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int SLOTS     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_tick,
  input  logic                         fsync,
  input  logic                         ser_in,
  input  logic                         lsb_first,
  input  logic                         tx_wr,
  input  logic [SLOT_BITS*SLOTS-1:0]   tx_data,
  input  logic                         flag_clr,
  output logic                         ser_out,
  output logic [SLOT_BITS*SLOTS-1:0]   rx_word,
  output logic                         irq,
  output logic                         irq_flag
);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int FRM_W  = $clog2(SLOTS);
  localparam int WORD_W = SLOT_BITS * SLOTS;

  bit_order_e       order;
  logic             bit_valid, last_bit, word_end;
  logic [BIT_W-1:0] slot_idx;
  logic [FRM_W-1:0] frame_cnt;
  logic             flag_d;

  assign order = lsb_first ? ORDER_LSB_FIRST : ORDER_MSB_FIRST;

  tdm_slot_timer #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS), .BIT_W(BIT_W), .FRM_W(FRM_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
    .bit_valid(bit_valid), .slot_idx(slot_idx), .frame_cnt(frame_cnt),
    .last_bit(last_bit), .word_end(word_end)
  );

  tdm_rx_path #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS), .BIT_W(BIT_W), .FRM_W(FRM_W),
                .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .order(order), .bit_valid(bit_valid),
    .frame_cnt(frame_cnt), .last_bit(last_bit), .word_end(word_end), .rx_word(rx_word)
  );

  tdm_tx_path #(.SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS), .BIT_W(BIT_W), .FRM_W(FRM_W),
                .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data), .order(order),
    .bit_tick(bit_tick), .bit_valid(bit_valid), .slot_idx(slot_idx),
    .frame_cnt(frame_cnt), .word_end(word_end), .ser_out(ser_out)
  );

  always_comb begin
    flag_d = irq_flag;
    if (flag_clr) flag_d = 1'b0;
    if (word_end) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      irq      <= word_end;
      irq_flag <= flag_d;
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R5
  AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr && !word_end) |=> irq_flag); // R6
  AST_IRQ_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && $past(irq)) |-> $stable(rx_word)); // R5
endmodule

// File: tb/tdm_bchan_buffer_bench.sv
module tdm_bchan_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0, fsync = 1'b0, ser_in = 1'b0, lsb_first = 1'b0;
  logic        tx_wr = 1'b0, flag_clr = 1'b0;
  logic [31:0] tx_data = '0;
  logic        ser_out, irq, irq_flag;
  logic [31:0] rx_word;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_shadow, exp_hold, last_rx;

  always #2.5 clk = ~clk;

  tdm_bchan_buffer u_tdm_bchan_buffer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync), .ser_in(ser_in),
    .lsb_first(lsb_first), .tx_wr(tx_wr), .tx_data(tx_data), .flag_clr(flag_clr),
    .ser_out(ser_out), .rx_word(rx_word), .irq(irq), .irq_flag(irq_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [31:0] w);
    @(negedge clk); tx_wr = 1'b1; tx_data = w;
    @(negedge clk); tx_wr = 1'b0;
    exp_hold = w;
  endtask

  task automatic tick(input logic fs, input logic d);
    @(negedge clk); bit_tick = 1'b1; fsync = fs; ser_in = d;
    @(negedge clk); bit_tick = 1'b0; fsync = 1'b0;
  endtask

  // Four slots; mid_wr writes the holding word after slot 1 (R8).
  task automatic run_word(input logic [31:0] rxw, input logic mode, input int gap,
                          input logic hold_clr, input logic mid_wr, input logic [31:0] mid_val);
    logic [7:0] rb, tb;
    lsb_first = mode;
    flag_clr  = hold_clr;
    for (int f = 0; f < 4; f++) begin
      rb = rxw[31-8*f -: 8];
      tb = exp_shadow[31-8*f -: 8];
      for (int i = 0; i < 8; i++) begin
        tick(i == 0, mode ? rb[i] : rb[7-i]);
        check(mode ? "R4 tx bit" : "R3 tx bit", 32'(ser_out), 32'(mode ? tb[i] : tb[7-i]));
      end
      if (f < 3) begin
        check("R5 no irq mid word", 32'(irq), 32'd0);
        check("R10 rx held", rx_word, last_rx);
        if (mid_wr && f == 1) write_tx(mid_val);
        for (int g = 0; g < gap; g++) begin
          tick(1'b0, 1'($urandom));
          check("R9 idle line", 32'(ser_out), 32'd1);
        end
      end
    end
    check("R2 rx word", rx_word, rxw);
    check("R5 irq high", 32'(irq), 32'd1);
    check("R6 flag set", 32'(irq_flag), 32'd1);
    last_rx    = rxw;
    exp_shadow = exp_hold;
    @(negedge clk);
    check("R5 irq drop", 32'(irq), 32'd0);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    exp_shadow = '1; exp_hold = '1; last_rx = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rx reset", rx_word, 32'hFFFF_FFFF);
    check("R1 irq reset", 32'(irq), 32'd0);
    check("R1 flag reset", 32'(irq_flag), 32'd0);
    check("R1 line reset", 32'(ser_out), 32'd1);

    // R1/R7: first group sends ones; written word follows.
    write_tx(32'h5A3C_0FF0);
    run_word(32'hA1B2_C3D4, 1'b0, 2, 1'b0, 1'b0, '0);
    // R8: no new write, word repeats; flag stays set (R6).
    check("R6 flag sticky", 32'(irq_flag), 32'd1);
    run_word(32'h0123_4567, 1'b1, 1, 1'b0, 1'b0, '0);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R6 flag cleared", 32'(irq_flag), 32'd0);
    // R8: write during group leaves bytes in flight intact.
    run_word(32'h8001_7FFE, 1'b1, 0, 1'b0, 1'b1, 32'hC3A5_1E69);
    // R6: clear held through irq, set wins.
    run_word(32'hDEAD_BEEF, 1'b0, 3, 1'b1, 1'b0, '0);
    check("R6 clear after irq", 32'(irq_flag), 32'd0);

    for (int n = 0; n < 24; n++) begin
      if ($urandom % 2 == 0) write_tx($urandom);
      run_word($urandom, 1'($urandom), int'($urandom % 4), 1'($urandom % 4 == 0),
               1'($urandom % 3 == 0), $urandom);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule